// File: doc/BRIEF.md
# Reconfigurable Fixed-Width Booth Multiplication Engine

This block is a purely combinational radix-4 Booth multiplier for two 8-bit two's-complement operands. A 2-bit opcode picks how the shared partial-product hardware is used:

- one 8x8 product cut down to its 8 most significant bits;
- two independent 4x4 products, each cut down to 4 bits;
- one exact 4x4 product;
- the sum of two cut-down 4x4 products.

The four Booth rows are split into two halves. The lower half is driven by `y_in[3:0]` and the upper half by `y_in[7:4]`.

Each truncated product keeps one partial-product column below its output LSB. The columns further down are dropped. The dropped value is approximated by an adaptive bias, which has three parts:

- the bits of the column just below the kept one, counted and folded in pairwise;
- a flag for an unpaired leftover bit in each half;
- a single half-LSB constant.

When the two halves form one wide product, their two leftover flags merge into one carry. This keeps the constant from being added twice. A last-stage adder joins the halves, and an output multiplexer arranges the result byte for the selected mode.

The subword modes form the cross products `x_in[7:4]*y_in[3:0]` and `x_in[3:0]*y_in[7:4]`. Pairing the subwords this way lets each Booth half keep its own rows. In the exact mode, the lower half is silenced by forcing its multiplier bits to zero before recoding.

Top module: `rfm_booth_engine`

## Requirements
- R1: `op_in` selects the mode. 2'b00 is the wide truncated product, 2'b01 the dual truncated products, 2'b10 the exact half product, and 2'b11 the sum of the two truncated half products. The output follows the inputs combinationally.
- R2: With `op_in`=2'b00, the signed `result` lies within one of floor(X*Y/256), where X and Y are the signed operands.
- R3: With `op_in`=2'b01, signed `result[3:0]` lies in [f, f+1], where f = floor(A/16) and A = signed `x_in[7:4]` * signed `y_in[3:0]`.
- R4: With `op_in`=2'b01, signed `result[7:4]` lies in [g, g+1], where g = floor(B/16) and B = signed `x_in[3:0]` * signed `y_in[7:4]`.
- R5: With `op_in`=2'b10, `result` equals signed `x_in[7:4]` * signed `y_in[7:4]` exactly, whatever the low nibbles hold.
- R6: With `op_in`=2'b11, `result` equals the sign-extended sum of the two nibbles that `op_in`=2'b01 gives for the same operands.
- R7: With `op_in`=2'b11, signed `result` lies in [f+g, f+g+2].
- R8: In the wide mode, the first bias-correction bit is the AND of both halves' leftover flags and the second is 0. In the two subword-truncated modes, each bit follows its own half's flag.
- R9: Zero operands give a zero result in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 8 | Multiplicand, two's complement (two 4-bit subwords in subword modes) |
| y_in | input | 8 | Multiplier, two's complement (two 4-bit subwords in subword modes) |
| op_in | input | 2 | Mode select, encoding per R1 |
| result | output | 8 | Product byte arranged per mode |

## Verification
Every operand pair in the full 8-bit by 8-bit space is driven in all four modes.

- The exact mode must match bit for bit. This separates correct Booth recoding and subword sign handling from near misses.
- The truncated modes are held to bounds against the floor of the true product. A bias that is added twice or dropped pushes values outside those bounds at large-magnitude and most-negative operands.
- The summing mode is compared with the dual mode on the same operands. This shows whether the sign extension before the last-stage add is right.
- Directed vectors cover the most-negative corners (0x80, 0x88), all-ones operands and zero operands.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    localparam int OP_W   = 8;
    localparam int SUB_W  = OP_W / 2;
    localparam int PROD_W = 2 * OP_W;
    localparam int POS_W  = $clog2(PROD_W);
    localparam int CW_W   = 4;
    localparam int ROWS_PER_HALF = SUB_W / 2;

    typedef enum logic [1:0] {
        OP_WIDE_FW  = 2'b00,
        OP_DUAL_FW  = 2'b01,
        OP_HALF_EX  = 2'b10,
        OP_DOT_FW   = 2'b11
    } op_e;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_t;

    typedef struct packed {
        logic [PROD_W-1:0] kept;
        logic [1:0]        pairs;
        logic              km;
    } half_t;

    // control word: bit0 wide, bit1 split rows, bit2 exact half, bit3 summed output
    function automatic logic [CW_W-1:0] decode_op(op_e op);
        logic [CW_W-1:0] cw;
        case (op)
            OP_WIDE_FW: cw = 4'b0001;
            OP_DUAL_FW: cw = 4'b0010;
            OP_HALF_EX: cw = 4'b0100;
            default:    cw = 4'b1010;
        endcase
        return cw;
    endfunction

    function automatic booth_t booth_recode(logic [2:0] trip);
        booth_t b;
        b.one = trip[0] ^ trip[1];
        b.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
        b.neg = trip[2] & ~(trip[1] & trip[0]);
        return b;
    endfunction

    function automatic logic [OP_W-1:0] sext_sub(logic [SUB_W-1:0] n);
        return {{(OP_W-SUB_W){n[SUB_W-1]}}, n};
    endfunction

    function automatic logic [PROD_W-1:0] sext_nib_wide(logic [SUB_W-1:0] n);
        return {{(PROD_W-SUB_W){n[SUB_W-1]}}, n};
    endfunction

endpackage

// File: rtl/rfm_booth_row.sv
module rfm_booth_row
    import rfm_pkg::*;
#(
    parameter int MW = OP_W,
    parameter int PW = PROD_W,
    parameter int SW = POS_W
) (
    input  booth_t          bt,
    input  logic [MW-1:0]   mcand,
    input  logic [SW-1:0]   shift,
    input  logic [SW-1:0]   cut,
    output logic [PW-1:0]   kept,
    output logic [1:0]      edge_cnt
);
    logic [MW:0]    sel;
    logic [MW:0]    pp;
    logic [PW-1:0]  term;
    logic [PW-1:0]  negw;
    logic [PW-1:0]  mask;
    logic [SW-1:0]  ecol;

    always_comb begin
        if (bt.one)      sel = {mcand[MW-1], mcand};
        else if (bt.two) sel = {mcand, 1'b0};
        else             sel = '0;
        pp   = bt.neg ? ~sel : sel;
        term = {{(PW-MW-1){pp[MW]}}, pp} << shift;
        negw = PW'(bt.neg) << shift;
        mask = ~((PW'(1) << cut) - PW'(1));
        kept = (term & mask) + (negw & mask);
        ecol = cut - SW'(1);
        if (cut != '0)
            edge_cnt = {1'b0, term[ecol]} + {1'b0, negw[ecol]};
        else
            edge_cnt = 2'd0;
    end

endmodule

// File: rtl/rfm_half.sv
module rfm_half
    import rfm_pkg::*;
#(
    parameter int MW   = OP_W,
    parameter int PW   = PROD_W,
    parameter int SW   = POS_W,
    parameter int ROWS = ROWS_PER_HALF
) (
    input  logic [MW-1:0]          mcand,
    input  logic [ROWS-1:0][2:0]   trips,
    input  logic [SW-1:0]          base,
    input  logic [SW-1:0]          cut,
    output half_t                  res
);
    localparam int CNT_W = $clog2(2 * ROWS + 1);

    logic [ROWS-1:0][PW-1:0] row_kept;
    logic [ROWS-1:0][1:0]    row_edge;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        booth_t         bt;
        logic [SW-1:0]  sh;
        assign bt = booth_recode(trips[r]);
        assign sh = base + SW'(2 * r);
        rfm_booth_row #(.MW(MW), .PW(PW), .SW(SW)) u_row (
            .bt       (bt),
            .mcand    (mcand),
            .shift    (sh),
            .cut      (cut),
            .kept     (row_kept[r]),
            .edge_cnt (row_edge[r])
        );
    end

    logic [PW-1:0]    sum;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        sum = '0;
        cnt = '0;
        for (int r = 0; r < ROWS; r++) begin
            sum = sum + row_kept[r];
            cnt = cnt + CNT_W'(row_edge[r]);
        end
        res.kept  = sum;
        res.pairs = 2'(cnt >> 1);
        res.km    = cnt[0];
    end

endmodule

// File: rtl/rfm_calib.sv
module rfm_calib
    import rfm_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    input  logic            km_lo,
    input  logic            km_hi,
    output logic            fix_lo,
    output logic            fix_hi
);
    always_comb begin
        if (cw[0]) begin
            fix_lo = km_lo & km_hi;
            fix_hi = 1'b0;
        end else if (cw[1]) begin
            fix_lo = km_lo;
            fix_hi = km_hi;
        end else begin
            fix_lo = 1'b0;
            fix_hi = 1'b0;
        end
    end
endmodule

// File: rtl/rfm_final.sv
module rfm_final
    import rfm_pkg::*;
#(
    parameter int PW = PROD_W,
    parameter int OW = OP_W,
    parameter int HW = SUB_W
) (
    input  logic [CW_W-1:0] cw,
    input  logic [PW-1:0]   va,
    input  logic [PW-1:0]   vb,
    output logic [OW-1:0]   result
);
    logic [PW-1:0] add_a;
    logic [PW-1:0] add_b;
    logic [PW-1:0] sum;

    always_comb begin
        if (cw[3]) begin
            add_a = sext_nib_wide(va[OW-1:HW]);
            add_b = sext_nib_wide(vb[OW-1:HW]);
        end else begin
            add_a = va;
            add_b = cw[1] ? '0 : vb;
        end
        sum = add_a + add_b;
        case ({cw[1], cw[3]})
            2'b00:   result = cw[2] ? sum[OW-1:0] : sum[PW-1:OW];
            2'b10:   result = {vb[OW-1:HW], sum[OW-1:HW]};
            2'b11:   result = sum[OW-1:0];
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/rfm_booth_engine.sv
module rfm_booth_engine
    import rfm_pkg::*;
(
    input  logic [OP_W-1:0] x_in,
    input  logic [OP_W-1:0] y_in,
    input  logic [1:0]      op_in,
    output logic [OP_W-1:0] result
);
    localparam int WIDE_CUT = OP_W - 1;
    localparam int SUB_CUT  = SUB_W - 1;
    localparam int UNIT_W   = 4;

    logic [CW_W-1:0] cw;
    logic            wide, split, exact;

    assign cw    = decode_op(op_e'(op_in));
    assign wide  = cw[0];
    assign split = cw[1];
    assign exact = cw[2];

    // lower half: rows from y_in[3:0]
    logic [SUB_W-1:0]              y_lo;
    logic [OP_W-1:0]               mc_lo, mc_hi;
    logic [ROWS_PER_HALF-1:0][2:0] tr_lo, tr_hi;
    logic [POS_W-1:0]              base_hi, cut_lo, cut_hi;
    half_t                         h_lo, h_hi;

    always_comb begin
        y_lo     = exact ? '0 : y_in[SUB_W-1:0];
        mc_lo    = wide ? x_in : sext_sub(x_in[OP_W-1:SUB_W]);
        tr_lo[0] = {y_lo[1], y_lo[0], 1'b0};
        tr_lo[1] = y_lo[3:1];
        cut_lo   = wide ? POS_W'(WIDE_CUT) : POS_W'(SUB_CUT);

        if (wide)       mc_hi = x_in;
        else if (exact) mc_hi = sext_sub(x_in[OP_W-1:SUB_W]);
        else            mc_hi = sext_sub(x_in[SUB_W-1:0]);
        tr_hi[0] = {y_in[5], y_in[4], wide ? y_in[3] : 1'b0};
        tr_hi[1] = y_in[7:5];
        base_hi  = wide ? POS_W'(SUB_W) : '0;
        if (wide)       cut_hi = POS_W'(WIDE_CUT);
        else if (exact) cut_hi = '0;
        else            cut_hi = POS_W'(SUB_CUT);
    end

    rfm_half u_half_lo (
        .mcand (mc_lo),
        .trips (tr_lo),
        .base  ('0),
        .cut   (cut_lo),
        .res   (h_lo)
    );

    rfm_half u_half_hi (
        .mcand (mc_hi),
        .trips (tr_hi),
        .base  (base_hi),
        .cut   (cut_hi),
        .res   (h_hi)
    );

    logic km_lo, km_hi, scc1, scc2;
    assign km_lo = h_lo.km;
    assign km_hi = h_hi.km;

    rfm_calib u_calib (
        .cw     (cw),
        .km_lo  (km_lo),
        .km_hi  (km_hi),
        .fix_lo (scc1),
        .fix_hi (scc2)
    );

    logic [UNIT_W-1:0] units_w, units_lo, units_hi;
    logic [PROD_W-1:0] va, vb;

    always_comb begin
        units_w  = UNIT_W'(h_lo.pairs) + UNIT_W'(h_hi.pairs)
                 + UNIT_W'(scc1) + UNIT_W'(scc2) + UNIT_W'(1);
        units_lo = UNIT_W'(h_lo.pairs) + UNIT_W'(scc1) + UNIT_W'(1);
        units_hi = UNIT_W'(h_hi.pairs) + UNIT_W'(scc2) + UNIT_W'(1);
        if (wide) begin
            va = h_lo.kept + (PROD_W'(units_w) << WIDE_CUT);
            vb = h_hi.kept;
        end else if (split) begin
            va = h_lo.kept + (PROD_W'(units_lo) << SUB_CUT);
            vb = h_hi.kept + (PROD_W'(units_hi) << SUB_CUT);
        end else begin
            va = h_lo.kept;
            vb = h_hi.kept;
        end
    end

    rfm_final u_final (
        .cw     (cw),
        .va     (va),
        .vb     (vb),
        .result (result)
    );

endmodule

// File: rtl/rfm_booth_engine_chk.sv
module rfm_booth_engine_chk (
    input logic [7:0] x_in,
    input logic [7:0] y_in,
    input logic [1:0] op_in,
    input logic [7:0] result,
    input logic       km_lo,
    input logic       km_hi,
    input logic       scc1,
    input logic       scc2
);
    int p_w, e_w, p_a, p_b, f_a, f_b, r_w, n_lo, n_hi;

    always_comb begin
        p_w  = int'($signed(x_in)) * int'($signed(y_in));
        e_w  = p_w >>> 8;
        p_a  = int'($signed(x_in[7:4])) * int'($signed(y_in[3:0]));
        p_b  = int'($signed(x_in[3:0])) * int'($signed(y_in[7:4]));
        f_a  = p_a >>> 4;
        f_b  = p_b >>> 4;
        r_w  = int'($signed(result));
        n_lo = int'($signed(result[3:0]));
        n_hi = int'($signed(result[7:4]));

        if (op_in == 2'b00) begin
            AST_WIDE_WITHIN_ONE: assert (r_w >= e_w - 1 && r_w <= e_w + 1) else $error("wide bound"); // R2
            AST_CAL_WIDE: assert (scc2 == 1'b0 && scc1 == (km_lo & km_hi)) else $error("wide calib"); // R8
        end
        if (op_in == 2'b01) begin
            AST_DUAL_LO_BOUND: assert (n_lo >= f_a && n_lo <= f_a + 1) else $error("dual lo"); // R3
            AST_DUAL_HI_BOUND: assert (n_hi >= f_b && n_hi <= f_b + 1) else $error("dual hi"); // R4
        end
        if (op_in[0]) begin
            AST_CAL_SPLIT: assert (scc1 == km_lo && scc2 == km_hi) else $error("split calib"); // R8
        end
        if (op_in == 2'b10) begin
            AST_HALF_EXACT: assert (r_w == int'($signed(x_in[7:4])) * int'($signed(y_in[7:4]))) else $error("half exact"); // R5
        end
        if (op_in == 2'b11) begin
            AST_DOT_BOUND: assert (r_w >= f_a + f_b && r_w <= f_a + f_b + 2) else $error("dot bound"); // R7
        end
    end
endmodule

bind rfm_booth_engine rfm_booth_engine_chk u_chk (
    .x_in   (x_in),
    .y_in   (y_in),
    .op_in  (op_in),
    .result (result),
    .km_lo  (km_lo),
    .km_hi  (km_hi),
    .scc1   (scc1),
    .scc2   (scc2)
);

// File: tb/rfm_booth_engine_bench.sv
module rfm_booth_engine_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] x   = '0;
    logic [7:0] y   = '0;
    logic [1:0] op  = '0;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    localparam int WATCHDOG = 150000;

    always #5 clk = ~clk;

    rfm_booth_engine u_rfm_booth_engine (
        .x_in   (x),
        .y_in   (y),
        .op_in  (op),
        .result (result)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL timeout: actual %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]        op;
        logic [7:0]        x;
        logic [7:0]        y;
        logic signed [8:0] lo;
        logic signed [8:0] hi;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'h80, 8'h80,  9'sd63,  9'sd65},
        '{2'b00, 8'h7F, 8'h7F,  9'sd62,  9'sd64},
        '{2'b00, 8'h80, 8'h7F, -9'sd65, -9'sd63},
        '{2'b00, 8'h00, 8'hA5, -9'sd1,   9'sd1},
        '{2'b00, 8'hFF, 8'hFF, -9'sd1,   9'sd1},
        '{2'b10, 8'h70, 8'h70,  9'sd49,  9'sd49},
        '{2'b10, 8'h80, 8'h80,  9'sd64,  9'sd64},
        '{2'b10, 8'h8F, 8'h7A, -9'sd56, -9'sd56},
        '{2'b10, 8'h0F, 8'hF0,  9'sd0,   9'sd0},
        '{2'b11, 8'h78, 8'h78, -9'sd8,  -9'sd6},
        '{2'b11, 8'h88, 8'h88,  9'sd8,   9'sd10}
    };

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b);
        op = o;
        x  = a;
        y  = b;
        #1;
    endtask

    function automatic string vec_tag(input logic [1:0] o);
        case (o)
            2'b00:   return "R1 R2 table";
            2'b10:   return "R1 R5 table";
            default: return "R1 R7 table";
        endcase
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: zero operands in every mode
        for (int o = 0; o < 4; o++) begin
            apply(2'(o), 8'h00, 8'h00);
            check_range("R9 zero operands", int'($signed(result)), 0, 0);
        end

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].x, VECS[i].y);
            check_range(vec_tag(VECS[i].op), int'($signed(result)),
                        int'(VECS[i].lo), int'(VECS[i].hi));
        end

        for (int xi = 0; xi < 256; xi++) begin
            for (int yi = 0; yi < 256; yi++) begin
                logic [7:0] xa, yb;
                int p_w, e_w, f_a, f_b, n_lo, n_hi, exact;
                xa    = 8'(xi);
                yb    = 8'(yi);
                p_w   = int'($signed(xa)) * int'($signed(yb));
                e_w   = p_w >>> 8;
                f_a   = (int'($signed(xa[7:4])) * int'($signed(yb[3:0]))) >>> 4;
                f_b   = (int'($signed(xa[3:0])) * int'($signed(yb[7:4]))) >>> 4;
                exact = int'($signed(xa[7:4])) * int'($signed(yb[7:4]));

                apply(2'b00, xa, yb);
                check_range("R2 wide truncated", int'($signed(result)), e_w - 1, e_w + 1);

                apply(2'b01, xa, yb);
                n_lo = int'($signed(result[3:0]));
                n_hi = int'($signed(result[7:4]));
                check_range("R3 dual low nibble", n_lo, f_a, f_a + 1);
                check_range("R4 dual high nibble", n_hi, f_b, f_b + 1);

                apply(2'b10, xa, yb);
                check_range("R5 half exact", int'($signed(result)), exact, exact);

                apply(2'b11, xa, yb);
                check_range("R6 sum equals dual nibbles", int'($signed(result)), n_lo + n_hi, n_lo + n_hi);
                check_range("R7 sum bound", int'($signed(result)), f_a + f_b, f_a + f_b + 2);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule